// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits on the byte-write path of a page-programmed flash model. It watches every write (address and data) and picks out the multi-cycle unlock sequences that change the device's mode. It drives four mode effects: turning software write protection on, turning it off, starting a chip erase, and entering or leaving product-ID mode. Writes that are not part of a sequence are either forwarded to the page buffer as ordinary data, through a one-cycle `pass_wr` pulse, or dropped, depending on the protection flag.

Command matching looks at address bits 14:0 and data bits 7:0 only. The short three-write sequences and the long six-write sequences start with the same two writes, so the decoder branches on the data of the third write, and again on the data of the sixth. When protection is on, a page load is accepted only after the three-write enable sequence. That sequence opens a load window, and the window stays open while writes keep arriving within `LOAD_TIMEOUT` cycles of each other.

The protection flag models a non-volatile bit. The power-on reset `rst_n` does not change it. It is forced to the as-shipped (unprotected) state only by the separate retention clear `nv_clr_n`. ID mode and the sequence state are volatile and return to their initial values on `rst_n`.

States are `ST_IDLE`, `ST_C1`, `ST_C2`, `ST_C3`, `ST_C4`, `ST_C5` and `ST_LOAD`. Command patterns are named P1 = AAh at 5555h and P2 = 55h at 2AAAh. The transitions, each taken on a write, are:
- idle→C1 on P1;
- C1→C2 on P2;
- C2→LOAD on A0h at 5555h;
- C2→C3 on 80h at 5555h;
- C2→idle on F0h at 5555h (ID exit);
- C3→C4 on P1;
- C4→C5 on P2;
- C5→idle on 20h, 10h or 60h at 5555h;
- any other write in C1 to C5 goes back to idle (a break).

The only transition taken without a write is load→idle, when no write has arrived for `LOAD_TIMEOUT` cycles.

Top module: `unlock_seq_decoder`

## Requirements
- R1: Asserting `rst_n` clears `id_mode`, `pass_wr`, `erase_start` and `id_data` to 0 and returns the sequence state to idle. Asserting `nv_clr_n` clears `prot_on` to 0. All outputs are registered and reflect a write or read one clock after the strobe edge.
- R2: While `prot_on` is 0 and the decoder is idle, a write that is not AAh at 5555h gives `pass_wr` = 1 for one cycle.
- R3: The writes AAh at 5555h, 55h at 2AAAh, A0h at 5555h set `prot_on` to 1 and enter the load window. The command writes themselves never give `pass_wr`.
- R4: While `prot_on` is 1, a write outside the load window is dropped (`pass_wr` stays 0). Inside the window every write passes. The window closes after `LOAD_TIMEOUT` consecutive cycles with no write.
- R5: The six writes AAh at 5555h, 55h at 2AAAh, 80h at 5555h, AAh at 5555h, 55h at 2AAAh, 20h at 5555h clear `prot_on` to 0.
- R6: The same six-write prefix ending in 10h at 5555h gives `erase_start` = 1 for exactly one cycle.
- R7: The six-write prefix ending in 60h at 5555h sets `id_mode` to 1. The three writes AAh at 5555h, 55h at 2AAAh, F0h at 5555h clear it.
- R8: A read while `id_mode` is 1 returns `id_data` = DAh for address 0, C1h for address 1 and 00h for any other address, one cycle after `rd_en`. With `id_mode` at 0, or with no read, `id_data` is 00h.
- R9: A write that does not match the next expected step of a sequence returns the decoder to idle. That write gives `pass_wr` only if `prot_on` is 0.
- R10: `rst_n` leaves `prot_on` unchanged and clears `id_mode`.
- R11: Address bits above bit 14 do not affect command matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low; clears volatile state |
| nv_clr_n | input | 1 | Retention clear, active low; forces the protection flag to unprotected |
| wr_en | input | 1 | Byte write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| prot_on | output | 1 | Software write protection flag |
| erase_start | output | 1 | One-cycle chip-erase start pulse |
| id_mode | output | 1 | Product-ID mode active |
| id_data | output | 8 | ID byte returned for the read one cycle earlier |
| pass_wr | output | 1 | The write one cycle earlier goes to the page buffer |

## Verification
A wrong sequence state shows at the ports on the very next write. A step that fails to advance, or a break that fails to reset, either lets a command byte leak out as `pass_wr` or makes the closing write of a sequence have no effect on `prot_on`, `id_mode` or `erase_start`, one cycle after that write. A load window that never closes or closes early shows up as the next protected write being passed or dropped incorrectly. The bench therefore probes just inside and just outside the timeout. A reset that touches the protection flag shows up as a changed `prot_on` at the first cycle after `rst_n` is released.

// File: rtl/unlock_seq_pkg.sv
package unlock_seq_pkg;
    localparam int CMD_W = 15;
    localparam logic [CMD_W-1:0] CMD_ADDR_A = 15'h5555;
    localparam logic [CMD_W-1:0] CMD_ADDR_B = 15'h2AAA;
    localparam logic [7:0] KEY_FIRST   = 8'hAA;
    localparam logic [7:0] KEY_SECOND  = 8'h55;
    localparam logic [7:0] OP_PROT_ON  = 8'hA0;
    localparam logic [7:0] OP_LONG     = 8'h80;
    localparam logic [7:0] OP_ID_EXIT  = 8'hF0;
    localparam logic [7:0] OP_PROT_OFF = 8'h20;
    localparam logic [7:0] OP_ERASE    = 8'h10;
    localparam logic [7:0] OP_ID_ENTER = 8'h60;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_C1,
        ST_C2,
        ST_C3,
        ST_C4,
        ST_C5,
        ST_LOAD
    } seq_state_e;
endpackage

// File: rtl/unlock_cmd_match.sv
module unlock_cmd_match
    import unlock_seq_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data,
    output logic              hit_first,
    output logic              hit_second,
    output logic              at_cmd_a
);
    logic [CMD_W-1:0] low;
    logic             unused_hi;

    assign low       = addr[CMD_W-1:0];
    assign unused_hi = ^addr[ADDR_W-1:CMD_W];

    assign at_cmd_a   = (low == CMD_ADDR_A);
    assign hit_first  = at_cmd_a && (data == KEY_FIRST);
    assign hit_second = (low == CMD_ADDR_B) && (data == KEY_SECOND);
endmodule

// File: rtl/unlock_load_timer.sv
module unlock_load_timer #(
    parameter int LOAD_TIMEOUT = 15000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_load,
    input  logic wr_en,
    output logic expire
);
    localparam int CNT_W = (LOAD_TIMEOUT > 2) ? $clog2(LOAD_TIMEOUT) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOAD_TIMEOUT - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!in_load || wr_en) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expire = in_load && !wr_en && (cnt_q == CNT_LAST);
endmodule

// File: rtl/unlock_id_rom.sv
module unlock_id_rom #(
    parameter int         ADDR_W   = 17,
    parameter logic [7:0] MFR_CODE = 8'hDA,
    parameter logic [7:0] DEV_CODE = 8'hC1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              id_mode,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        id_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_data <= 8'h00;
        end else if (rd_en && id_mode) begin
            if (rd_addr == ADDR_W'(0)) begin
                id_data <= MFR_CODE;
            end else if (rd_addr == ADDR_W'(1)) begin
                id_data <= DEV_CODE;
            end else begin
                id_data <= 8'h00;
            end
        end else begin
            id_data <= 8'h00;
        end
    end
endmodule

// File: rtl/unlock_seq_decoder.sv
module unlock_seq_decoder
    import unlock_seq_pkg::*;
#(
    parameter int         ADDR_W       = 17,
    parameter int         LOAD_TIMEOUT = 15000,
    parameter logic [7:0] MFR_CODE     = 8'hDA,
    parameter logic [7:0] DEV_CODE     = 8'hC1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nv_clr_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              prot_on,
    output logic              erase_start,
    output logic              id_mode,
    output logic [7:0]        id_data,
    output logic              pass_wr
);
    seq_state_e st_q, st_d;
    logic prot_q, prot_d;
    logic idm_q, idm_d;
    logic pass_d, erase_d;
    logic hit_first, hit_second, at_cmd_a, expire;

    unlock_cmd_match #(.ADDR_W(ADDR_W)) u_match (
        .addr       (wr_addr),
        .data       (wr_data),
        .hit_first  (hit_first),
        .hit_second (hit_second),
        .at_cmd_a   (at_cmd_a)
    );

    unlock_load_timer #(.LOAD_TIMEOUT(LOAD_TIMEOUT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_load (st_q == ST_LOAD),
        .wr_en   (wr_en),
        .expire  (expire)
    );

    unlock_id_rom #(
        .ADDR_W   (ADDR_W),
        .MFR_CODE (MFR_CODE),
        .DEV_CODE (DEV_CODE)
    ) u_rom (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .id_mode (idm_q),
        .rd_addr (rd_addr),
        .id_data (id_data)
    );

    // State register (volatile: cleared by the power-on reset)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state and output decode
    always_comb begin
        st_d    = st_q;
        prot_d  = prot_q;
        idm_d   = idm_q;
        pass_d  = 1'b0;
        erase_d = 1'b0;
        if (wr_en) begin
            unique case (st_q)
                ST_IDLE: begin
                    if (hit_first) st_d = ST_C1;
                    else           pass_d = !prot_q;
                end
                ST_C1, ST_C4: begin
                    if (hit_second) begin
                        st_d = (st_q == ST_C1) ? ST_C2 : ST_C5;
                    end else begin
                        st_d   = ST_IDLE;
                        pass_d = !prot_q;
                    end
                end
                ST_C3: begin
                    if (hit_first) begin
                        st_d = ST_C4;
                    end else begin
                        st_d   = ST_IDLE;
                        pass_d = !prot_q;
                    end
                end
                ST_C2: begin
                    st_d = ST_IDLE;
                    if (at_cmd_a && wr_data == OP_PROT_ON) begin
                        prot_d = 1'b1;
                        st_d   = ST_LOAD;
                    end else if (at_cmd_a && wr_data == OP_LONG) begin
                        st_d = ST_C3;
                    end else if (at_cmd_a && wr_data == OP_ID_EXIT) begin
                        idm_d = 1'b0;
                    end else begin
                        pass_d = !prot_q;
                    end
                end
                ST_C5: begin
                    st_d = ST_IDLE;
                    if (at_cmd_a && wr_data == OP_PROT_OFF) begin
                        prot_d = 1'b0;
                    end else if (at_cmd_a && wr_data == OP_ERASE) begin
                        erase_d = 1'b1;
                    end else if (at_cmd_a && wr_data == OP_ID_ENTER) begin
                        idm_d = 1'b1;
                    end else begin
                        pass_d = !prot_q;
                    end
                end
                ST_LOAD: begin
                    pass_d = 1'b1;
                end
                default: st_d = ST_IDLE;
            endcase
        end else if (expire) begin
            st_d = ST_IDLE;
        end
    end

    // Registered outputs (volatile part)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idm_q       <= 1'b0;
            pass_wr     <= 1'b0;
            erase_start <= 1'b0;
        end else begin
            idm_q       <= idm_d;
            pass_wr     <= pass_d;
            erase_start <= erase_d;
        end
    end

    // Retained protection flag: untouched by rst_n
    always_ff @(posedge clk or negedge nv_clr_n) begin
        if (!nv_clr_n) begin
            prot_q <= 1'b0;
        end else begin
            prot_q <= prot_d;
        end
    end

    assign prot_on = prot_q;
    assign id_mode = idm_q;
endmodule

// File: rtl/unlock_seq_checker.sv
module unlock_seq_checker #(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              nv_clr_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              prot_on,
    input logic              erase_start,
    input logic              id_mode,
    input logic [7:0]        id_data,
    input logic              pass_wr
);
    logic unused_addr;
    assign unused_addr = ^{wr_addr, rd_addr};

    // R2
    pass_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n || !nv_clr_n)
        pass_wr |-> $past(wr_en));

    // R3
    prot_rise_chk: assert property (@(posedge clk) disable iff (!rst_n || !nv_clr_n)
        $rose(prot_on) |-> $past(wr_en && wr_data == 8'hA0));

    // R5
    prot_fall_chk: assert property (@(posedge clk) disable iff (!rst_n || !nv_clr_n)
        $fell(prot_on) |-> $past(wr_en && wr_data == 8'h20));

    // R6
    erase_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n || !nv_clr_n)
        erase_start |=> !erase_start);

    // R6
    erase_src_chk: assert property (@(posedge clk) disable iff (!rst_n || !nv_clr_n)
        erase_start |-> $past(wr_en && wr_data == 8'h10));

    // R7
    id_enter_chk: assert property (@(posedge clk) disable iff (!rst_n || !nv_clr_n)
        $rose(id_mode) |-> $past(wr_en && wr_data == 8'h60));

    // R8
    id_data_src_chk: assert property (@(posedge clk) disable iff (!rst_n || !nv_clr_n)
        (id_data != 8'h00) |-> $past(rd_en && id_mode));
endmodule

bind unlock_seq_decoder unlock_seq_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/unlock_seq_decoder_test.sv
`timescale 1ns/1ps
module unlock_seq_decoder_test;
    localparam int AW = 17;
    localparam int TO = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          nv_clr_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          prot_on, erase_start, id_mode, pass_wr;
    logic [7:0]    id_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic strobe_seen = 1'b0;

    typedef struct {
        bit         pass;
        bit         erase;
        bit         prot;
        bit         idm;
        logic [7:0] rdata;
        string      req;
    } exp_t;

    exp_t q[$];

    unlock_seq_decoder #(.ADDR_W(AW), .LOAD_TIMEOUT(TO)) uut (
        .clk(clk), .rst_n(rst_n), .nv_clr_n(nv_clr_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .prot_on(prot_on), .erase_start(erase_start), .id_mode(id_mode),
        .id_data(id_data), .pass_wr(pass_wr)
    );

    always #10 clk = ~clk;

    always @(posedge clk) strobe_seen <= wr_en | rd_en;

    // Monitor: pops one expectation per strobe and compares
    always @(negedge clk) begin
        if (strobe_seen) begin
            exp_t e;
            checks++;
            if (q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard: result with no expectation");
            end else begin
                e = q.pop_front();
                if (pass_wr !== e.pass || erase_start !== e.erase || prot_on !== e.prot ||
                    id_mode !== e.idm || id_data !== e.rdata) begin
                    errors++;
                    $display("FAIL %s: got pass=%b erase=%b prot=%b id=%b data=%h, expected pass=%b erase=%b prot=%b id=%b data=%h",
                             e.req, pass_wr, erase_start, prot_on, id_mode, id_data,
                             e.pass, e.erase, e.prot, e.idm, e.rdata);
                end
            end
        end
    end

    task automatic chk(input logic [7:0] act, input logic [7:0] expv, input string req);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: got %h, expected %h", req, act, expv);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input bit p, input bit e,
                      input bit pr, input bit im, input string req);
        exp_t x;
        x.pass = p; x.erase = e; x.prot = pr; x.idm = im; x.rdata = 8'h00; x.req = req;
        q.push_back(x);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [7:0] d, input bit pr, input bit im,
                      input string req);
        exp_t x;
        x.pass = 1'b0; x.erase = 1'b0; x.prot = pr; x.idm = im; x.rdata = d; x.req = req;
        q.push_back(x);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic prefix6(input logic [7:0] last, input bit pr, input bit im,
                           input bit e_end, input bit pr_end, input bit im_end, input string req);
        wr(17'h05555, 8'hAA, 0, 0, pr, im, req);
        wr(17'h02AAA, 8'h55, 0, 0, pr, im, req);
        wr(17'h05555, 8'h80, 0, 0, pr, im, req);
        wr(17'h05555, 8'hAA, 0, 0, pr, im, req);
        wr(17'h02AAA, 8'h55, 0, 0, pr, im, req);
        wr(17'h05555, last,  0, e_end, pr_end, im_end, req);
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        finish_run();
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        nv_clr_n = 1'b1;
        rst_n    = 1'b1;
        // R1 reset state
        chk({7'd0, prot_on}, 8'd0, "R1 prot_on");
        chk({7'd0, id_mode}, 8'd0, "R1 id_mode");
        chk({6'd0, pass_wr, erase_start}, 8'd0, "R1 pulses");
        chk(id_data, 8'h00, "R1 id_data");

        // R2 ordinary write while unprotected
        wr(17'h00100, 8'h12, 1, 0, 0, 0, "R2");

        // R3 enable protection
        wr(17'h05555, 8'hAA, 0, 0, 0, 0, "R3");
        wr(17'h02AAA, 8'h55, 0, 0, 0, 0, "R3");
        wr(17'h05555, 8'hA0, 0, 0, 1, 0, "R3");

        // R4 load window inside and outside the timeout
        wr(17'h00200, 8'h33, 1, 0, 1, 0, "R4 in window");
        idle(TO - 2);
        wr(17'h00201, 8'h34, 1, 0, 1, 0, "R4 gap below timeout");
        idle(TO + 2);
        wr(17'h00202, 8'h35, 0, 0, 1, 0, "R4 dropped after timeout");

        // R9 broken sequence while protected
        wr(17'h05555, 8'hAA, 0, 0, 1, 0, "R9");
        wr(17'h00300, 8'h34, 0, 0, 1, 0, "R9 break dropped");
        wr(17'h02AAA, 8'h55, 0, 0, 1, 0, "R9 back in idle");

        // R11 upper address bits ignored
        wr(17'h15555, 8'hAA, 0, 0, 1, 0, "R11");
        wr(17'h12AAA, 8'h55, 0, 0, 1, 0, "R11");
        wr(17'h15555, 8'hA0, 0, 0, 1, 0, "R11");
        wr(17'h07F00, 8'h5A, 1, 0, 1, 0, "R11 window opened");
        idle(TO + 2);

        // R10 reset keeps protection
        do_reset();
        chk({7'd0, prot_on}, 8'd1, "R10 prot kept");
        chk({7'd0, id_mode}, 8'd0, "R10 id_mode");

        // R7 / R8 product ID
        prefix6(8'h60, 1, 0, 0, 1, 1, "R7 enter");
        rd(17'h00000, 8'hDA, 1, 1, "R8 addr0");
        rd(17'h00001, 8'hC1, 1, 1, "R8 addr1");
        rd(17'h00005, 8'h00, 1, 1, "R8 other addr");
        wr(17'h05555, 8'hAA, 0, 0, 1, 1, "R7 exit");
        wr(17'h02AAA, 8'h55, 0, 0, 1, 1, "R7 exit");
        wr(17'h05555, 8'hF0, 0, 0, 1, 0, "R7 exit");
        rd(17'h00000, 8'h00, 1, 0, "R8 outside ID mode");

        // R6 chip erase pulse
        prefix6(8'h10, 1, 0, 1, 1, 0, "R6");
        @(negedge clk);
        chk({7'd0, erase_start}, 8'd0, "R6 pulse one cycle");

        // R10 reset clears ID mode
        prefix6(8'h60, 1, 0, 0, 1, 1, "R7 enter again");
        do_reset();
        chk({7'd0, id_mode}, 8'd0, "R10 id cleared");
        chk({7'd0, prot_on}, 8'd1, "R10 prot kept again");

        // R5 disable protection, then R2 again
        prefix6(8'h20, 1, 0, 0, 0, 0, "R5");
        wr(17'h00400, 8'h66, 1, 0, 0, 0, "R2 after disable");

        // R9 broken sequence while unprotected passes the breaking write
        wr(17'h05555, 8'hAA, 0, 0, 0, 0, "R9");
        wr(17'h02AAA, 8'h55, 0, 0, 0, 0, "R9");
        wr(17'h00400, 8'h77, 1, 0, 0, 0, "R9 break passed");

        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard: %0d results missing, expected 0", q.size());
        end
        finish_run();
    end
endmodule